// File: doc/BRIEF.md
# Virtual Address Translation Mode Selector

This block is the first stage of an address translation pipeline. For each request it looks at the translation mode bits, the current privilege level and four direct-map window registers. It then picks one of four outcomes. The address may be passed straight through as a physical address. It may be mapped through the first matching window. It may be rejected because its upper bits are not a sign extension. Otherwise it is handed to a later page-table lookup stage, which is not part of this block.

Direct and window outcomes carry a physical address and read/write/execute permissions. The other two outcomes carry zeros. Each result is registered and comes with a one-hot path indicator and the index of the window that matched. The block works in two address modes, 64-bit and 32-bit, and the two modes form window addresses differently.

Top module: `xlat_mode_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` is 0 and `out_path`, `out_paddr`, `out_perm` and `out_win_idx` are all 0.
- R2: A request accepted on `req_valid` gives its result exactly one clock later with `out_valid` = 1. Whenever `out_valid` is 1, `out_path` has exactly one bit set: bit 0 direct, bit 1 window, bit 2 bad address, bit 3 page-table lookup. When `out_valid` is 0, `out_path` is 0.
- R3: When `direct_en` = 1 and `paging_en` = 0, the path is direct and the windows are ignored. `out_paddr` is the effective address truncated to PA_W bits, and `out_perm` = 3'b111. The permission bits are bit 0 read, bit 1 write and bit 2 execute.
- R4: The privilege mask has bit 0 set when `priv` = 0 and bit 3 set when `priv` = 3. Levels 1 and 2 give an empty mask, so no window can match at those levels.
- R5: A window matches when its enable field `cfg[3:0]` ANDed with the privilege mask is nonzero and its segment field equals the address segment. Among the matching windows, the one with the lowest index wins, and its index appears on `out_win_idx`.
- R6: In 64-bit mode, the address segment is `vaddr[63:60]` and is compared with `cfg[63:60]`. On a match, `out_paddr` = `vaddr[47:0]`.
- R7: In 32-bit mode, only `vaddr[31:0]` is used and the upper half is ignored. The segment is `vaddr[31:29]` and is compared with `cfg[31:29]`. On a match, `out_paddr` = {`cfg[27:25]`, `vaddr[28:0]`}, zero-extended.
- R8: A window match grants `out_perm` = 3'b111.
- R9: When neither the direct mode nor a window applies, and `vaddr[63:48]` is neither all zeros nor all ones, the path is bad address with `out_paddr` = 0 and `out_perm` = 0.
- R10: When neither the direct mode nor a window applies and the address is canonical, the path is page-table lookup with `out_paddr` = 0, `out_perm` = 0 and `out_win_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 64 | Virtual address |
| mode64 | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| direct_en | input | 1 | Direct-address mode bit |
| paging_en | input | 1 | Paging mode bit |
| priv | input | 2 | Current privilege level, 0 to 3 |
| win_cfg | input | 256 | Four 64-bit window registers; window i occupies bits [64*i+63:64*i] |
| out_valid | output | 1 | Result valid |
| out_path | output | 4 | One-hot outcome: direct, window, bad, lookup |
| out_paddr | output | 48 | Physical address |
| out_perm | output | 3 | Permissions: read, write, execute |
| out_win_idx | output | 2 | Index of the matching window |

## Verification
Every result is due exactly one clock after its request, because one register stage lies between the request inputs and all outputs. The bench changes inputs just after a falling edge, so the next rising edge captures them. It then compares all outputs with a behavioural model at the following falling edge, which keeps each check exactly one cycle behind its stimulus. Idle cycles are compared too, so a stray `out_valid` or a nonzero path on an idle cycle is caught.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PATH_W      = 4;
  localparam int PATH_DIRECT = 0;
  localparam int PATH_WIN    = 1;
  localparam int PATH_BAD    = 2;
  localparam int PATH_LOOKUP = 3;
  localparam int PERM_W      = 3;
  localparam int EN_W        = 4;

  // Privilege level to window-enable mask: kernel -> bit 0, user -> bit 3
  function automatic logic [EN_W-1:0] priv_mask(input logic [1:0] lvl);
    logic [EN_W-1:0] m;
    m = '0;
    m[0] = (lvl == 2'd0);
    m[EN_W-1] = (lvl == 2'd3);
    return m;
  endfunction
endpackage

// File: rtl/xlat_win_cmp.sv
module xlat_win_cmp #(
  parameter int VA_W      = 64,
  parameter int VIRT_W    = 48,
  parameter int PA_W      = 48,
  parameter int CFG_W     = 64,
  parameter int A32_W     = 32,
  parameter int SEG64_LSB = 60,
  parameter int SEG32_LSB = 29,
  parameter int PSEG_LSB  = 25
) (
  input  logic [CFG_W-1:0]        cfg,
  input  logic [VA_W-1:0]         vaddr,
  input  logic                    mode64,
  input  logic [xlat_pkg::EN_W-1:0] pmask,
  output logic                    hit,
  output logic [PA_W-1:0]         paddr
);
  localparam int SEG64_W = VA_W - SEG64_LSB;
  localparam int SEG32_W = A32_W - SEG32_LSB;

  logic seg_eq64, seg_eq32, priv_ok;
  logic [A32_W-1:0] pa32;

  assign priv_ok  = |(cfg[xlat_pkg::EN_W-1:0] & pmask);
  assign seg_eq64 = cfg[CFG_W-1 -: SEG64_W] == vaddr[VA_W-1 -: SEG64_W];
  assign seg_eq32 = cfg[A32_W-1 -: SEG32_W] == vaddr[A32_W-1 -: SEG32_W];
  assign pa32     = {cfg[PSEG_LSB +: SEG32_W], vaddr[SEG32_LSB-1:0]};

  always_comb begin
    hit   = priv_ok && (mode64 ? seg_eq64 : seg_eq32);
    paddr = '0;
    if (mode64) paddr[VIRT_W-1:0] = vaddr[VIRT_W-1:0];
    else        paddr[A32_W-1:0]  = pa32;
  end
endmodule

// File: rtl/xlat_win_pick.sv
module xlat_win_pick #(
  parameter int NWIN  = 4,
  parameter int PA_W  = 48,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [NWIN-1:0]      hit_vec,
  input  logic [NWIN*PA_W-1:0] paddr_flat,
  output logic                 any,
  output logic [IDX_W-1:0]     idx,
  output logic [PA_W-1:0]      paddr
);
  always_comb begin
    any   = |hit_vec;
    idx   = '0;
    paddr = '0;
    // Walk downward so the lowest matching index is the last assignment
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        idx   = IDX_W'(i);
        paddr = paddr_flat[i*PA_W +: PA_W];
      end
    end
  end
endmodule

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel #(
  parameter int VA_W      = 64,
  parameter int VIRT_W    = 48,
  parameter int PA_W      = 48,
  parameter int NWIN      = 4,
  parameter int CFG_W     = 64,
  parameter int A32_W     = 32,
  parameter int SEG64_LSB = 60,
  parameter int SEG32_LSB = 29,
  parameter int PSEG_LSB  = 25,
  localparam int IDX_W    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   mode64,
  input  logic                   direct_en,
  input  logic                   paging_en,
  input  logic [1:0]             priv,
  input  logic [NWIN*CFG_W-1:0]  win_cfg,
  output logic                   out_valid,
  output logic [3:0]             out_path,
  output logic [PA_W-1:0]        out_paddr,
  output logic [2:0]             out_perm,
  output logic [IDX_W-1:0]       out_win_idx
);
  import xlat_pkg::*;

  localparam int HI_W = VA_W - VIRT_W;

  logic [VA_W-1:0]      va_eff;
  logic [EN_W-1:0]      pmask;
  logic [NWIN-1:0]      hit_vec;
  logic [NWIN*PA_W-1:0] pa_flat;
  logic                 win_any;
  logic [IDX_W-1:0]     win_idx;
  logic [PA_W-1:0]      win_pa;
  logic                 direct, canon;
  logic [HI_W-1:0]      hi_bits;

  assign va_eff  = mode64 ? req_vaddr : {{(VA_W-A32_W){1'b0}}, req_vaddr[A32_W-1:0]};
  assign pmask   = priv_mask(priv);
  assign direct  = direct_en && !paging_en;
  assign hi_bits = va_eff[VA_W-1:VIRT_W];
  assign canon   = (&hi_bits) || !(|hi_bits);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    xlat_win_cmp #(
      .VA_W(VA_W), .VIRT_W(VIRT_W), .PA_W(PA_W), .CFG_W(CFG_W), .A32_W(A32_W),
      .SEG64_LSB(SEG64_LSB), .SEG32_LSB(SEG32_LSB), .PSEG_LSB(PSEG_LSB)
    ) u_cmp (
      .cfg   (win_cfg[g*CFG_W +: CFG_W]),
      .vaddr (va_eff),
      .mode64(mode64),
      .pmask (pmask),
      .hit   (hit_vec[g]),
      .paddr (pa_flat[g*PA_W +: PA_W])
    );
  end

  xlat_win_pick #(.NWIN(NWIN), .PA_W(PA_W)) u_pick (
    .hit_vec   (hit_vec),
    .paddr_flat(pa_flat),
    .any       (win_any),
    .idx       (win_idx),
    .paddr     (win_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_path    <= '0;
      out_paddr   <= '0;
      out_perm    <= '0;
      out_win_idx <= '0;
    end else begin
      out_valid   <= req_valid;
      out_path    <= '0;
      out_paddr   <= '0;
      out_perm    <= '0;
      out_win_idx <= '0;
      if (req_valid) begin
        if (direct) begin
          out_path[PATH_DIRECT] <= 1'b1;
          out_paddr             <= va_eff[PA_W-1:0];
          out_perm              <= '1;
        end else if (win_any) begin
          out_path[PATH_WIN] <= 1'b1;
          out_paddr          <= win_pa;
          out_perm           <= '1;
          out_win_idx        <= win_idx;
        end else if (!canon) begin
          out_path[PATH_BAD] <= 1'b1;
        end else begin
          out_path[PATH_LOOKUP] <= 1'b1;
        end
      end
    end
  end

  // R2: result follows the request by one cycle
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R2: exactly one path bit per valid result
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_path) == 1);
  // R2: no path indication on idle cycles
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_path == '0);
  // R3: direct mode wins over everything else
  a_r3_direct_first: assert property (@(posedge clk) disable iff (rst)
    (req_valid && direct_en && !paging_en) |=> out_path[PATH_DIRECT]);
  // R8: window match grants all permissions
  a_r8_win_perm: assert property (@(posedge clk) disable iff (rst)
    out_path[PATH_WIN] |-> out_perm == 3'b111);
  // R9: bad address carries no address or permission
  a_r9_bad_zero: assert property (@(posedge clk) disable iff (rst)
    out_path[PATH_BAD] |-> (out_perm == '0 && out_paddr == '0));
  // R4: privilege levels 1 and 2 never produce a window result
  a_r4_mid_priv: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !direct && (priv == 2'd1 || priv == 2'd2)) |=> !out_path[PATH_WIN]);
endmodule

// File: tb/xlat_mode_sel_test.sv
module xlat_mode_sel_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [63:0]  req_vaddr;
  logic         mode64, direct_en, paging_en;
  logic [1:0]   priv;
  logic [255:0] win_cfg;
  logic         out_valid;
  logic [3:0]   out_path;
  logic [47:0]  out_paddr;
  logic [2:0]   out_perm;
  logic [1:0]   out_win_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  xlat_mode_sel uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .mode64(mode64), .direct_en(direct_en), .paging_en(paging_en), .priv(priv),
    .win_cfg(win_cfg), .out_valid(out_valid), .out_path(out_path),
    .out_paddr(out_paddr), .out_perm(out_perm), .out_win_idx(out_win_idx)
  );

  logic        e_valid;
  logic [3:0]  e_path;
  logic [47:0] e_paddr;
  logic [2:0]  e_perm;
  logic [1:0]  e_idx;

  // Behavioural model of the requirements
  task automatic model();
    logic [63:0] va;
    logic [3:0]  mask;
    logic [15:0] hi;
    int          found;
    logic [63:0] c;
    e_valid = req_valid; e_path = 0; e_paddr = 0; e_perm = 0; e_idx = 0;
    if (!req_valid) return;
    va = mode64 ? req_vaddr : {32'd0, req_vaddr[31:0]};
    if (direct_en && !paging_en) begin
      e_path = 4'b0001; e_paddr = va[47:0]; e_perm = 3'b111; return;
    end
    mask = 0;
    if (priv == 0) mask[0] = 1;
    if (priv == 3) mask[3] = 1;
    found = -1;
    for (int i = 0; i < 4; i++) begin
      c = win_cfg[i*64 +: 64];
      if (found < 0 && (c[3:0] & mask) != 0) begin
        if (mode64 ? (c[63:60] == va[63:60]) : (c[31:29] == va[31:29])) found = i;
      end
    end
    if (found >= 0) begin
      c = win_cfg[found*64 +: 64];
      e_path = 4'b0010; e_perm = 3'b111; e_idx = found[1:0];
      e_paddr = mode64 ? va[47:0] : {16'd0, c[27:25], va[28:0]};
      return;
    end
    hi = va[63:48];
    if (hi == 16'h0000 || hi == 16'hFFFF) e_path = 4'b1000;
    else e_path = 4'b0100;
  endtask

  task automatic cmp(input string req);
    checks++;
    if ({out_valid, out_path, out_paddr, out_perm, out_win_idx} !==
        {e_valid, e_path, e_paddr, e_perm, e_idx}) begin
      fails++;
      $display("FAIL %s: got v=%b path=%b pa=%h perm=%b idx=%0d, expected v=%b path=%b pa=%h perm=%b idx=%0d",
        req, out_valid, out_path, out_paddr, out_perm, out_win_idx,
        e_valid, e_path, e_paddr, e_perm, e_idx);
    end
  endtask

  // Drive after a falling edge, compare one full cycle later
  task automatic step(input string req, input logic v, input logic [63:0] a,
                      input logic m64, input logic da, input logic pg, input logic [1:0] p);
    req_valid = v; req_vaddr = a; mode64 = m64; direct_en = da; paging_en = pg; priv = p;
    model();
    @(negedge clk);
    cmp(req);
  endtask

  function automatic logic [63:0] w64(input logic [3:0] en, input logic [3:0] seg);
    return {seg, 56'd0, en};
  endfunction
  function automatic logic [63:0] w32(input logic [3:0] en, input logic [2:0] seg, input logic [2:0] pseg);
    return {32'd0, seg, 1'b0, pseg, 21'd0, en};
  endfunction

  initial begin
    rst = 1; req_valid = 0; req_vaddr = 0; mode64 = 1; direct_en = 0; paging_en = 1;
    priv = 0; win_cfg = 0;
    repeat (3) @(negedge clk);
    e_valid = 0; e_path = 0; e_paddr = 0; e_perm = 0; e_idx = 0;
    cmp("R1 reset");
    rst = 0;
    step("R1 after reset", 0, 64'h0, 1, 0, 1, 0);

    // 64-bit windows: 0 kernel seg 9, 1 user seg 9, 2 both seg 8, 3 both seg 9
    win_cfg = {w64(4'b1001, 4'h9), w64(4'b1001, 4'h8), w64(4'b1000, 4'h9), w64(4'b0001, 4'h9)};
    step("R3 direct", 1, 64'h9ABC_DEF0_1234_5678, 1, 1, 0, 0);
    step("R3 direct noncanon", 1, 64'h1234_5678_9ABC_DEF0, 1, 1, 0, 3);
    step("R5 R6 kernel win0", 1, 64'h9000_1234_5678_9ABC, 1, 0, 1, 0);
    step("R4 R5 user win1", 1, 64'h9000_0000_0000_0042, 1, 0, 1, 3);
    step("R6 win2", 1, 64'h8000_7FFF_FFFF_F000, 1, 0, 1, 3);
    step("R4 priv1 no window", 1, 64'h9000_0000_0000_0042, 1, 0, 1, 1);
    step("R4 priv2 no window", 1, 64'hFFFF_8000_0000_0010, 1, 0, 1, 2);
    step("R9 bad address", 1, 64'h0001_0000_0000_0000, 1, 0, 1, 0);
    step("R10 lookup low", 1, 64'h0000_7FFF_0000_1000, 1, 0, 1, 0);
    step("R10 lookup high", 1, 64'hFFFF_8000_0000_1000, 1, 1, 1, 3);
    step("R2 idle", 0, 64'h9000_0000_0000_0000, 1, 0, 1, 0);
    step("R8 win perm da0pg0", 1, 64'h9123_0000_0000_0001, 1, 0, 0, 0);

    // 32-bit windows
    win_cfg = {w64(4'b0000, 4'h0), w32(4'b1001, 3'd5, 3'd2), w32(4'b1000, 3'd4, 3'd7), w32(4'b0001, 3'd4, 3'd1)};
    step("R7 kernel win0", 1, 64'hDEAD_BEEF_8123_4567, 0, 0, 1, 0);
    step("R7 user win1", 1, 64'h0000_0000_9FFF_FFFF, 0, 0, 1, 3);
    step("R7 win2", 1, 64'h1111_1111_A000_0004, 0, 0, 1, 3);
    step("R7 upper ignored lookup", 1, 64'h1234_0000_0000_0100, 0, 0, 1, 0);
    step("R3 direct 32", 1, 64'hFFFF_FFFF_8765_4321, 0, 1, 0, 3);

    // Mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      win_cfg = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      step("R2 R5 random", 1'($urandom), {$urandom, $urandom}, 1'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule